// File: doc/BRIEF.md
# Connection Memory Block Programmer

This block fills two connection memories with one fixed pattern in a single bulk pass. One is a backplane memory. The other is a local memory that has a low half and a high half. Software first sets a mode bit. It then writes a programming word that raises a go bit and carries two small data fields in the same write. The block latches both fields at that moment and waits for the next frame-start strobe. It then writes the backplane pattern into every channel location during the first frame, one location per clock. During the second frame it writes the local pattern into every location of both local halves. At the third frame strobe it clears the go bit. Software reads that bit back to see that the fill is done.

Clearing the go bit, or clearing the mode bit, while the fill is under way cancels it at once. Locations already written keep their values. Each channel memory must have no more locations than a frame has clock cycles. A single word holds the backplane field at bits 13:11 and the local field at bits 15:12. Every other bit of the written words is zero.

Top module: `cm_block_fill`

## Requirements
- R1: A fill starts only when a programming write sets the go bit, the go bit was 0 before that write, and the mode bit is already 1. A go write made while the mode bit is 0, or a go write that finds the go bit already 1, starts nothing and causes no memory write.
- R2: Every backplane word written carries the latched backplane field at bits 13:11, with bits 15, 14 and 10:0 at zero.
- R3: Every local-low word written carries the latched local field at bits 15:12, with bits 11:0 at zero. Every local-high word written is all zero.
- R4: The programming word places the go bit at bit 0, the local field at bits 4:1 and the backplane field at bits 7:5. A mode write takes a single bit. The go status output shows the stored go bit on the clock after any programming write.
- R5: On the clock after the first frame strobe that follows a start, the backplane sweep begins. It writes addresses 0 to DEPTH-1 in ascending order, one per clock, each exactly once.
- R6: On the clock after the second frame strobe, the local sweep begins. It writes both halves at addresses 0 to DEPTH-1 in ascending order, one per clock, each exactly once.
- R7: The go status stays 1 through both frames. It reads 0 on the clock after the third frame strobe that follows the start.
- R8: Programming writes with the go bit set that arrive during an active fill change neither the pattern nor the address sequence, and they do not restart the fill.
- R9: While a fill is active, a programming write with the go bit 0, or a mode write of 0, suppresses any memory write in that same clock and every clock after it. It clears the go status on the next clock. Locations written before it keep their values.
- R10: No write enable is asserted outside an active fill, and the backplane and local write enables are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | New mode bit value |
| prog_wr | input | 1 | Write strobe for the programming word |
| prog_wdata | input | PROG_W | Programming word: go, local field, backplane field |
| frame_sof | input | 1 | One-clock frame-start strobe |
| go_status | output | 1 | Stored go bit; falls when a fill completes or is cancelled |
| bp_addr | output | AW | Backplane memory write address |
| bp_wdata | output | WORD_W | Backplane memory write data |
| bp_we | output | 1 | Backplane memory write enable |
| lc_addr | output | AW | Local memory write address, shared by both halves |
| lc_lo_wdata | output | WORD_W | Local-low write data |
| lc_hi_wdata | output | WORD_W | Local-high write data |
| lc_we | output | 1 | Local memory write enable for both halves |

## Verification
A wrong phase in the controller shows at the ports within one frame. A sweep can run in the wrong frame, come twice, or never come. The go status can fall one strobe early or late. A stuck or skipping address counter shows as a location written twice or never, which becomes clear once a sweep ends, at most DEPTH clocks after its strobe. A bad field latch or formatter shows in the data of the very first word written. A fault in cancellation shows as one extra write in the cancelling clock, or as writes after it.

// File: rtl/cmbf_pkg.sv
package cmbf_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ARM   = 2'd1,
      PH_BACK  = 2'd2,
      PH_LOCAL = 2'd3
   } fill_phase_e;

endpackage

// File: rtl/cmbf_word_fmt.sv
module cmbf_word_fmt #(
   parameter int WORD_W  = 16,
   parameter int FLD_W   = 3,
   parameter int FLD_LSB = 11
) (
   input  logic [FLD_W-1:0]  fld,
   output logic [WORD_W-1:0] word
);

   localparam int FLD_MSB = FLD_LSB + FLD_W - 1;

   // Each bit is either routed from the field or tied low.
   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b >= FLD_LSB && b <= FLD_MSB) begin : g_fld
         assign word[b] = fld[b-FLD_LSB];
      end else begin : g_zero
         assign word[b] = 1'b0;
      end
   end

endmodule

// File: rtl/cmbf_sweep.sv
module cmbf_sweep #(
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kick,
   input  logic          halt,
   output logic [AW-1:0] addr,
   output logic          run
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         run  <= 1'b0;
      end else if (halt) begin
         run <= 1'b0;
      end else if (kick) begin
         addr <= '0;
         run  <= 1'b1;
      end else if (run) begin
         if (addr == LAST) begin
            run <= 1'b0;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmbf_ctrl.sv
module cmbf_ctrl
   import cmbf_pkg::*;
#(
   parameter int PROG_W = 8,
   parameter int GO_POS = 0,
   parameter int LC_POS = 1,
   parameter int LC_W   = 4,
   parameter int BP_POS = 5,
   parameter int BP_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_wdata,
   input  logic              prog_wr,
   input  logic [PROG_W-1:0] prog_wdata,
   input  logic              frame_sof,
   output fill_phase_e       phase,
   output logic              go_q,
   output logic [BP_W-1:0]   bp_fld,
   output logic [LC_W-1:0]   lc_fld,
   output logic              kick,
   output logic              abort
);

   logic mode_q;
   logic go_wr;
   logic mode_clr;
   logic active;
   logic start;
   logic done;

   assign go_wr    = prog_wdata[GO_POS];
   assign mode_clr = mode_wr && !mode_wdata;
   assign active   = (phase != PH_IDLE);

   // Only a rising go bit with mode already enabled arms a fill.
   assign start = prog_wr && go_wr && !go_q && mode_q && !mode_clr && !active;
   assign abort = active && ((prog_wr && !go_wr) || mode_clr);
   assign done  = (phase == PH_LOCAL) && frame_sof && !abort;
   assign kick  = frame_sof && !abort && ((phase == PH_ARM) || (phase == PH_BACK));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (mode_wr) begin
         mode_q <= mode_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q <= 1'b0;
      end else if (abort || done) begin
         go_q <= 1'b0;
      end else if (prog_wr) begin
         go_q <= go_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_fld <= '0;
         lc_fld <= '0;
      end else if (start) begin
         bp_fld <= prog_wdata[BP_POS +: BP_W];
         lc_fld <= prog_wdata[LC_POS +: LC_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else if (abort) begin
         phase <= PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE:  if (start)     phase <= PH_ARM;
            PH_ARM:   if (frame_sof) phase <= PH_BACK;
            PH_BACK:  if (frame_sof) phase <= PH_LOCAL;
            PH_LOCAL: if (frame_sof) phase <= PH_IDLE;
            default:                 phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cm_block_fill.sv
module cm_block_fill
   import cmbf_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int WORD_W     = 16,
   parameter int BP_FLD_W   = 3,
   parameter int BP_FLD_LSB = 11,
   parameter int LC_FLD_W   = 4,
   parameter int LC_FLD_LSB = 12,
   parameter int PROG_W     = 8,
   parameter int GO_POS     = 0,
   parameter int LC_POS     = 1,
   parameter int BP_POS     = 5,
   parameter int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_wdata,
   input  logic              prog_wr,
   input  logic [PROG_W-1:0] prog_wdata,
   input  logic              frame_sof,
   output logic              go_status,
   output logic [AW-1:0]     bp_addr,
   output logic [WORD_W-1:0] bp_wdata,
   output logic              bp_we,
   output logic [AW-1:0]     lc_addr,
   output logic [WORD_W-1:0] lc_lo_wdata,
   output logic [WORD_W-1:0] lc_hi_wdata,
   output logic              lc_we
);

   // Elaboration-time parameter checks.
   if (DEPTH < 1) begin : g_bad_depth
      $error("cm_block_fill: DEPTH must be at least 1");
   end
   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("cm_block_fill: AW too narrow for DEPTH");
   end
   if (BP_FLD_LSB + BP_FLD_W > WORD_W) begin : g_bad_bp
      $error("cm_block_fill: backplane field exceeds word");
   end
   if (LC_FLD_LSB + LC_FLD_W > WORD_W) begin : g_bad_lc
      $error("cm_block_fill: local field exceeds word");
   end
   if (GO_POS >= PROG_W || LC_POS + LC_FLD_W > PROG_W || BP_POS + BP_FLD_W > PROG_W) begin : g_bad_prog
      $error("cm_block_fill: programming word too narrow");
   end
   if ((GO_POS >= LC_POS && GO_POS < LC_POS + LC_FLD_W) ||
       (GO_POS >= BP_POS && GO_POS < BP_POS + BP_FLD_W) ||
       (LC_POS < BP_POS + BP_FLD_W && BP_POS < LC_POS + LC_FLD_W)) begin : g_bad_overlap
      $error("cm_block_fill: programming word fields overlap");
   end

   fill_phase_e         phase;
   logic                go_q;
   logic [BP_FLD_W-1:0] bp_fld;
   logic [LC_FLD_W-1:0] lc_fld;
   logic                kick;
   logic                abort;
   logic [AW-1:0]       sw_addr;
   logic                sw_run;

   cmbf_ctrl #(
      .PROG_W (PROG_W),
      .GO_POS (GO_POS),
      .LC_POS (LC_POS),
      .LC_W   (LC_FLD_W),
      .BP_POS (BP_POS),
      .BP_W   (BP_FLD_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .prog_wr    (prog_wr),
      .prog_wdata (prog_wdata),
      .frame_sof  (frame_sof),
      .phase      (phase),
      .go_q       (go_q),
      .bp_fld     (bp_fld),
      .lc_fld     (lc_fld),
      .kick       (kick),
      .abort      (abort)
   );

   cmbf_sweep #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) sweep_i (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (kick),
      .halt  (abort),
      .addr  (sw_addr),
      .run   (sw_run)
   );

   cmbf_word_fmt #(
      .WORD_W  (WORD_W),
      .FLD_W   (BP_FLD_W),
      .FLD_LSB (BP_FLD_LSB)
   ) bp_fmt_i (
      .fld  (bp_fld),
      .word (bp_wdata)
   );

   cmbf_word_fmt #(
      .WORD_W  (WORD_W),
      .FLD_W   (LC_FLD_W),
      .FLD_LSB (LC_FLD_LSB)
   ) lc_fmt_i (
      .fld  (lc_fld),
      .word (lc_lo_wdata)
   );

   assign lc_hi_wdata = '0;
   assign go_status   = go_q;
   assign bp_addr     = sw_addr;
   assign lc_addr     = sw_addr;

   // Cancellation masks the write in the very clock it is requested.
   assign bp_we = sw_run && (phase == PH_BACK)  && !abort;
   assign lc_we = sw_run && (phase == PH_LOCAL) && !abort;

endmodule

// File: rtl/cm_block_fill_chk.sv
module cm_block_fill_chk #(
   parameter int DEPTH      = 32,
   parameter int WORD_W     = 16,
   parameter int BP_FLD_W   = 3,
   parameter int BP_FLD_LSB = 11,
   parameter int LC_FLD_W   = 4,
   parameter int LC_FLD_LSB = 12,
   parameter int PROG_W     = 8,
   parameter int GO_POS     = 0,
   parameter int AW         = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wr,
   input logic              mode_wdata,
   input logic              prog_wr,
   input logic [PROG_W-1:0] prog_wdata,
   input logic              go_status,
   input logic [AW-1:0]     bp_addr,
   input logic [WORD_W-1:0] bp_wdata,
   input logic              bp_we,
   input logic [AW-1:0]     lc_addr,
   input logic [WORD_W-1:0] lc_lo_wdata,
   input logic [WORD_W-1:0] lc_hi_wdata,
   input logic              lc_we
);

   localparam logic [WORD_W-1:0] BP_MASK = WORD_W'(((1 << BP_FLD_W) - 1) << BP_FLD_LSB);
   localparam logic [WORD_W-1:0] LC_MASK = WORD_W'(((1 << LC_FLD_W) - 1) << LC_FLD_LSB);

   logic go_clr_wr;
   logic mode_clr_wr;
   assign go_clr_wr   = prog_wr && !prog_wdata[GO_POS];
   assign mode_clr_wr = mode_wr && !mode_wdata;

   AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bp_we && lc_we)); // R10
   AST_WE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_we || lc_we) |-> go_status); // R10
   AST_BP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      bp_we |-> ((bp_wdata & ~BP_MASK) == '0)); // R2
   AST_LC_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      lc_we |-> (((lc_lo_wdata & ~LC_MASK) == '0) && (lc_hi_wdata == '0))); // R3
   AST_BP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_we && $past(bp_we)) |-> ((bp_addr - $past(bp_addr)) == AW'(1))); // R5
   AST_LC_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_we && $past(lc_we)) |-> ((lc_addr - $past(lc_addr)) == AW'(1))); // R6
   AST_BP_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_we && $past(bp_we)) |-> $stable(bp_wdata)); // R8
   AST_LC_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_we && $past(lc_we)) |-> $stable(lc_lo_wdata)); // R8
   AST_CANCEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (go_clr_wr || mode_clr_wr) |-> (!bp_we && !lc_we)); // R9
   AST_CANCEL_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      go_clr_wr |=> !go_status); // R9
   AST_GO_RISE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(go_status) |-> $past(prog_wr)); // R4

endmodule

bind cm_block_fill cm_block_fill_chk #(
   .DEPTH      (DEPTH),
   .WORD_W     (WORD_W),
   .BP_FLD_W   (BP_FLD_W),
   .BP_FLD_LSB (BP_FLD_LSB),
   .LC_FLD_W   (LC_FLD_W),
   .LC_FLD_LSB (LC_FLD_LSB),
   .PROG_W     (PROG_W),
   .GO_POS     (GO_POS),
   .AW         (AW)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_wr     (mode_wr),
   .mode_wdata  (mode_wdata),
   .prog_wr     (prog_wr),
   .prog_wdata  (prog_wdata),
   .go_status   (go_status),
   .bp_addr     (bp_addr),
   .bp_wdata    (bp_wdata),
   .bp_we       (bp_we),
   .lc_addr     (lc_addr),
   .lc_lo_wdata (lc_lo_wdata),
   .lc_hi_wdata (lc_hi_wdata),
   .lc_we       (lc_we)
);

// File: tb/cm_block_fill_tb_top.sv
`timescale 1ns/1ps
module cm_block_fill_tb_top;

   localparam int DEPTH = 8;
   localparam int AW    = 3;
   localparam int FP    = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic        mode_wdata = 1'b0;
   logic        prog_wr = 1'b0;
   logic [7:0]  prog_wdata = '0;
   logic        frame_sof = 1'b0;
   logic        go_status;
   logic [AW-1:0] bp_addr, lc_addr;
   logic [15:0] bp_wdata, lc_lo_wdata, lc_hi_wdata;
   logic        bp_we, lc_we;

   always #2.5 clk = ~clk;

   cm_block_fill #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .prog_wr(prog_wr), .prog_wdata(prog_wdata), .frame_sof(frame_sof),
      .go_status(go_status), .bp_addr(bp_addr), .bp_wdata(bp_wdata), .bp_we(bp_we),
      .lc_addr(lc_addr), .lc_lo_wdata(lc_lo_wdata), .lc_hi_wdata(lc_hi_wdata), .lc_we(lc_we)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Write monitor, sampled at the falling edge.
   int          cyc = 0;
   int          last_sof = -10;
   int          seq_err = 0;
   int          bp_prev = 0;
   int          lc_prev = 0;
   int          bp_cnt [DEPTH];
   int          lc_cnt [DEPTH];
   logic [15:0] bp_v [DEPTH];
   logic [15:0] lo_v [DEPTH];
   logic [15:0] hi_v [DEPTH];
   int          both_err = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (bp_we && lc_we) both_err++;
         if (bp_we) begin
            bp_cnt[bp_addr]++;
            bp_v[bp_addr] = bp_wdata;
            if (bp_addr == 0) begin
               if (cyc != last_sof + 1) seq_err++;
            end else if (int'(bp_addr) != bp_prev + 1) seq_err++;
            bp_prev = int'(bp_addr);
         end
         if (lc_we) begin
            lc_cnt[lc_addr]++;
            lo_v[lc_addr] = lc_lo_wdata;
            hi_v[lc_addr] = lc_hi_wdata;
            if (lc_addr == 0) begin
               if (cyc != last_sof + 1) seq_err++;
            end else if (int'(lc_addr) != lc_prev + 1) seq_err++;
            lc_prev = int'(lc_addr);
         end
         if (frame_sof) last_sof = cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic prog(input logic go, input logic [3:0] lc, input logic [2:0] bp);
      prog_wr = 1'b1;
      prog_wdata = {bp, lc, go};
      tick();
      prog_wr = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      mode_wr = 1'b1;
      mode_wdata = m;
      tick();
      mode_wr = 1'b0;
   endtask

   task automatic frame(input bit poke, input logic [3:0] plc, input logic [2:0] pbp);
      frame_sof = 1'b1;
      tick();
      frame_sof = 1'b0;
      if (poke) begin
         repeat (3) tick();
         prog(1'b1, plc, pbp);
         repeat (FP - 5) tick();
      end else begin
         repeat (FP - 1) tick();
      end
   endtask

   task automatic clear_mon();
      for (int a = 0; a < DEPTH; a++) begin
         bp_cnt[a] = 0; lc_cnt[a] = 0;
         bp_v[a] = '0; lo_v[a] = '0; hi_v[a] = '0;
      end
      seq_err = 0;
      both_err = 0;
   endtask

   function automatic int total_writes();
      int s = 0;
      for (int a = 0; a < DEPTH; a++) s += bp_cnt[a] + lc_cnt[a];
      return s;
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      clear_mon();
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      // Reset state
      chk(go_status == 1'b0, "R10 reset go", int'(go_status), 0);
      chk(!bp_we && !lc_we, "R10 reset we", int'(bp_we) + int'(lc_we), 0);

      // R1: go written while mode is 0 starts nothing
      prog(1'b1, 4'h9, 3'h5);
      chk(go_status == 1'b1, "R4 go stored", int'(go_status), 1);
      repeat (3) frame(1'b0, 4'h0, 3'h0);
      chk(total_writes() == 0, "R1 mode off", total_writes(), 0);
      // R1: go already high, mode now 1, another go write is no edge
      set_mode(1'b1);
      prog(1'b1, 4'h9, 3'h5);
      repeat (3) frame(1'b0, 4'h0, 3'h0);
      chk(total_writes() == 0, "R1 level high", total_writes(), 0);
      chk(go_status == 1'b1, "R4 go held", int'(go_status), 1);
      prog(1'b0, 4'h0, 3'h0);
      chk(go_status == 1'b0, "R4 go cleared", int'(go_status), 0);

      // Full fills over every field value
      for (int v = 0; v < 16; v++) begin
         logic [2:0] bp;
         logic [3:0] lc;
         int tot;
         bp = 3'(v);
         lc = 4'(v);
         clear_mon();
         prog(1'b1, lc, bp);
         chk(go_status == 1'b1, "R4 go set", int'(go_status), 1);
         repeat (2) tick();
         frame(1'b1, ~lc, ~bp);
         chk(go_status == 1'b1, "R8 go kept by poke", int'(go_status), 1);
         frame(1'b1, ~lc, bp ^ 3'h2);
         chk(go_status == 1'b1, "R7 busy before third strobe", int'(go_status), 1);
         frame_sof = 1'b1;
         tick();
         frame_sof = 1'b0;
         chk(go_status == 1'b0, "R7 done after third strobe", int'(go_status), 0);
         repeat (FP - 1) tick();
         for (int a = 0; a < DEPTH; a++) begin
            chk(bp_cnt[a] == 1, "R5 bp once", bp_cnt[a], 1);
            chk(bp_v[a] == {2'b00, bp, 11'h0}, "R2 bp word", int'(bp_v[a]), int'({2'b00, bp, 11'h0}));
            chk(lc_cnt[a] == 1, "R6 lc once", lc_cnt[a], 1);
            chk(lo_v[a] == {lc, 12'h0}, "R3 lo word", int'(lo_v[a]), int'({lc, 12'h0}));
            chk(hi_v[a] == 16'h0, "R3 hi word", int'(hi_v[a]), 0);
         end
         chk(seq_err == 0, "R5 R6 order", seq_err, 0);
         chk(both_err == 0, "R10 exclusive", both_err, 0);
         tot = total_writes();
         frame(1'b0, 4'h0, 3'h0);
         chk(total_writes() == tot, "R10 idle frame", total_writes(), tot);
      end

      // R9: cancel by go=0 during the backplane sweep
      clear_mon();
      prog(1'b1, 4'h6, 3'h3);
      frame_sof = 1'b1;
      tick();
      frame_sof = 1'b0;
      tick();
      tick();
      prog(1'b0, 4'h0, 3'h0);
      chk(go_status == 1'b0, "R9 go cleared", int'(go_status), 0);
      repeat (FP) tick();
      repeat (2) frame(1'b0, 4'h0, 3'h0);
      for (int a = 0; a < DEPTH; a++) begin
         chk(bp_cnt[a] == ((a < 2) ? 1 : 0), "R9 bp partial", bp_cnt[a], (a < 2) ? 1 : 0);
      end
      chk(bp_v[1] == 16'h1800, "R9 kept word", int'(bp_v[1]), 16'h1800);
      chk(total_writes() == 2, "R9 no later writes", total_writes(), 2);

      // R9: cancel by mode=0 during the local sweep
      clear_mon();
      prog(1'b1, 4'hA, 3'h6);
      frame(1'b0, 4'h0, 3'h0);
      frame_sof = 1'b1;
      tick();
      frame_sof = 1'b0;
      repeat (4) tick();
      set_mode(1'b0);
      chk(go_status == 1'b0, "R9 mode cancel go", int'(go_status), 0);
      set_mode(1'b1);
      repeat (3) frame(1'b0, 4'h0, 3'h0);
      chk(total_writes() == DEPTH + 4, "R9 mode cancel count", total_writes(), DEPTH + 4);
      chk(lc_cnt[3] == 1 && lc_cnt[4] == 0, "R9 lc partial", lc_cnt[4], 0);
      chk(lo_v[2] == 16'hA000, "R9 lc kept", int'(lo_v[2]), 16'hA000);
      chk(go_status == 1'b0, "R1 no restart", int'(go_status), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule